// File: doc/BRIEF.md
# Key-Locked Watchdog Reset Timer

This block is a watchdog down-counter that can pull a system reset or raise an interrupt when it runs out. It advances only on cycles where a slow tick enable (nominally 32.768 kHz, so a 50 ms window is a load of 1638) is high. Software talks to it over a plain single-cycle register bus: a write strobe with address and data, and a combinational read-data port driven from the same address.

All control and load registers sit behind a key gate. The block leaves reset locked, and writes to the load or control registers are discarded until the 16-bit key 0xE551 has been written to the lock register. Any other value written there locks it again. The 32-bit timeout is assembled from two 16-bit halves. The high half is only staged. Writing the low half commits both halves to the counter in one step, so a half-written value is never counted.

Once started, the counter drops by one per tick. On reaching zero it raises a fixed-length reset pulse (when reset generation is enabled) and/or latches an interrupt (when the interrupt mode is selected). It then holds at zero until software reloads it.

Top module: `lockdog_timer`

## Requirements
- R1: After reset the lock register (offset 0x20) reads 1, the control register (offset 0x08) and both count halves (offsets 0x0C low, 0x10 high) read 0, and `sys_rst` and `wdt_irq` are low.
- R2: Writing 0xE551 to offset 0x20 makes that register read 0 (unlocked). Writing any other value to offset 0x20 makes it read 1 (locked).
- R3: While locked, writes to offsets 0x00, 0x04 and 0x08 have no effect on any register, on the count or on the running state. Reads still return the current contents.
- R4: A write to the high load half (offset 0x04) changes only the staged value read back at 0x04 and leaves the count unchanged. A write to the low load half (offset 0x00) loads the count with {staged high half, written low half} in the same edge.
- R5: With control bit 1 set, the count drops by exactly one on each clock edge where `tick_en` is high, and is unchanged on edges where it is low.
- R6: With control bits 1 and 3 set, the edge on which the count reaches zero starts a `sys_rst` pulse that is high for exactly RST_CYCLES clock cycles (default 4).
- R7: With control bit 3 clear, expiry produces no `sys_rst` pulse.
- R8: After expiry the count stays at 0 regardless of ticks until the low load half is written. That write also clears `wdt_irq`.
- R9: With control bit 2 set, expiry sets `wdt_irq`, which stays high until the next reload. With bit 2 clear, expiry leaves `wdt_irq` low.
- R10: With control bit 1 clear, the count holds its value whatever `tick_en` does.
- R11: The control register reads back bits 1, 2 and 3 as last written and 0 in every other bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per slow-clock tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| sys_rst | output | 1 | System reset pulse on expiry |
| wdt_irq | output | 1 | Expiry interrupt, held until reload |

## Verification
A lock state that is wrong on the inside shows up one cycle after the write that should have been discarded. The control or count read-back changes, or the count stops following the tick pattern. A count that is off by one moves the `sys_rst` rising edge by a whole tick period, and the bench catches this at the first sample after the expected expiry edge. A bad pulse counter lengthens or shortens `sys_rst` by at least one cycle, and a stuck expiry flag shows as a count that moves again after zero. Both are caught within a few cycles of the expiry.

// File: rtl/lockdog_pkg.sv
// Shared constants and types for the key-locked watchdog.
// Assumes byte offsets on the register bus and a 16-bit key.
package lockdog_pkg;

    localparam int unsigned OFS_LOAD_LO = 'h00;
    localparam int unsigned OFS_LOAD_HI = 'h04;
    localparam int unsigned OFS_CTRL    = 'h08;
    localparam int unsigned OFS_CNT_LO  = 'h0C;
    localparam int unsigned OFS_CNT_HI  = 'h10;
    localparam int unsigned OFS_LOCK    = 'h20;

    localparam logic [15:0] UNLOCK_KEY  = 16'hE551;

    localparam int unsigned CTRL_RUN_BIT  = 1;
    localparam int unsigned CTRL_MODE_BIT = 2;
    localparam int unsigned CTRL_RST_BIT  = 3;

    typedef struct packed {
        logic rst_en;
        logic irq_mode;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/lockdog_regs.sv
// Register file with key gate. It owns the lock flag, the staged load halves
// and the control bits, and it drives the combinational read mux.
// Assumes a single-cycle write strobe and a 16-bit key.
module lockdog_regs
    import lockdog_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_value,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_value,
    output logic              locked
);

    logic              sel_lo, sel_hi, sel_ctrl, sel_lock;
    logic              wr_open;
    logic [DATA_W-1:0] stage_lo, stage_hi;

    // Address decode for the writable registers.
    always_comb begin
        sel_lo   = (bus_addr == ADDR_W'(OFS_LOAD_LO));
        sel_hi   = (bus_addr == ADDR_W'(OFS_LOAD_HI));
        sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_lock = (bus_addr == ADDR_W'(OFS_LOCK));
        wr_open  = bus_wr && !locked;
    end

    // Lock flag: only the exact key unlocks, anything else locks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (bus_wr && sel_lock)
            locked <= (bus_wdata != DATA_W'(UNLOCK_KEY));
    end

    // Staged load halves, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lo <= '0;
            stage_hi <= '0;
        end else if (wr_open) begin
            if (sel_lo) stage_lo <= bus_wdata;
            if (sel_hi) stage_hi <= bus_wdata;
        end
    end

    // Control bits, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_open && sel_ctrl) begin
            ctrl.run      <= bus_wdata[CTRL_RUN_BIT];
            ctrl.irq_mode <= bus_wdata[CTRL_MODE_BIT];
            ctrl.rst_en   <= bus_wdata[CTRL_RST_BIT];
        end
    end

    // A low-half write commits both halves to the counter at once.
    always_comb begin
        load_stb   = wr_open && sel_lo;
        load_value = {stage_hi, bus_wdata};
    end

    // Read mux for every visible register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_LOAD_LO): bus_rdata = stage_lo;
            ADDR_W'(OFS_LOAD_HI): bus_rdata = stage_hi;
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[CTRL_RUN_BIT]  = ctrl.run;
                bus_rdata[CTRL_MODE_BIT] = ctrl.irq_mode;
                bus_rdata[CTRL_RST_BIT]  = ctrl.rst_en;
            end
            ADDR_W'(OFS_CNT_LO):  bus_rdata = cnt_value[DATA_W-1:0];
            ADDR_W'(OFS_CNT_HI):  bus_rdata = cnt_value[CNT_W-1:DATA_W];
            ADDR_W'(OFS_LOCK):    bus_rdata = DATA_W'(locked);
            default:              bus_rdata = '0;
        endcase
    end

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_lock && bus_wdata == DATA_W'(UNLOCK_KEY)) |=> !locked);

    // R2
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_lock && bus_wdata != DATA_W'(UNLOCK_KEY)) |=> locked);

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_wr && !sel_lock) |=>
            ($stable(ctrl) && $stable(stage_lo) && $stable(stage_hi)));

endmodule

// File: rtl/lockdog_counter.sv
// Down-counter advanced by the tick enable. It flags expiry when the count
// reaches zero and then holds at zero until reloaded. A load has priority
// over counting in the same cycle.
module lockdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_value,
    output logic [CNT_W-1:0] count,
    output logic             expire_evt
);

    logic expired;
    logic step;

    // A step is a tick while running and not already expired.
    always_comb begin
        step       = run && tick_en && !expired && !load_stb;
        expire_evt = step && (count <= CNT_W'(1));
    end

    // Count register and expiry latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            expired <= 1'b0;
        end else if (load_stb) begin
            count   <= load_value;
            expired <= 1'b0;
        end else if (expire_evt) begin
            count   <= '0;
            expired <= 1'b1;
        end else if (step) begin
            count   <= count - CNT_W'(1);
        end
    end

    // R5
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !expired && !load_stb && count > CNT_W'(1))
            |=> count == $past(count) - CNT_W'(1));

    // R10
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_stb) |=> $stable(count));

    // R8
    hold_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load_stb) |=> (count == '0));

endmodule

// File: rtl/lockdog_alarm.sv
// Expiry outputs: stretches the expiry event into a reset pulse of
// RST_CYCLES cycles and latches the interrupt until the next reload.
// Assumes an expiry event and a load never occur in the same cycle.
module lockdog_alarm #(
    parameter int RST_CYCLES = 4,
    localparam int PW = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_evt,
    input  logic rst_en,
    input  logic irq_mode,
    input  logic load_stb,
    output logic sys_rst,
    output logic irq
);

    generate
        if (RST_CYCLES == 1) begin : g_single
            logic pulse_q;
            // Single-cycle pulse needs only one flop.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse_q <= 1'b0;
                else        pulse_q <= expire_evt && rst_en;
            end
            assign sys_rst = pulse_q;
        end else begin : g_stretch
            logic [PW-1:0] pulse_cnt;
            // Load the pulse length on expiry, then count it down.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pulse_cnt <= '0;
                else if (expire_evt && rst_en)
                    pulse_cnt <= PW'(RST_CYCLES);
                else if (pulse_cnt != '0)
                    pulse_cnt <= pulse_cnt - PW'(1);
            end
            assign sys_rst = (pulse_cnt != '0);
        end
    endgenerate

    // Interrupt latch: set on expiry in interrupt mode, cleared on reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (load_stb)
            irq <= 1'b0;
        else if (expire_evt && irq_mode)
            irq <= 1'b1;
    end

    // R6
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_evt && rst_en) |=> sys_rst);

    // R7
    no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_evt && !rst_en && !sys_rst) |=> !sys_rst);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire_evt && irq_mode));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !irq);

endmodule

// File: rtl/lockdog_timer.sv
// Top of the key-locked watchdog: register file, tick-driven down-counter
// and expiry outputs. Assumes tick_en is already in the clk domain.
module lockdog_timer
    import lockdog_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst,
    output logic              wdt_irq
);

    localparam int CNT_W = 2 * DATA_W;

    ctrl_t            ctrl;
    logic             load_stb;
    logic [CNT_W-1:0] load_value;
    logic [CNT_W-1:0] count;
    logic             expire_evt;
    logic             locked;

    lockdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_value  (count),
        .bus_rdata  (bus_rdata),
        .ctrl       (ctrl),
        .load_stb   (load_stb),
        .load_value (load_value),
        .locked     (locked)
    );

    lockdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .run        (ctrl.run),
        .load_stb   (load_stb),
        .load_value (load_value),
        .count      (count),
        .expire_evt (expire_evt)
    );

    lockdog_alarm #(.RST_CYCLES(RST_CYCLES)) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_evt (expire_evt),
        .rst_en     (ctrl.rst_en),
        .irq_mode   (ctrl.irq_mode),
        .load_stb   (load_stb),
        .sys_rst    (sys_rst),
        .irq        (wdt_irq)
    );

    // R3
    locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !load_stb);

endmodule

// File: tb/sim_lockdog_timer.sv
// Scoreboard bench: check tasks push expected items, a monitor pops and
// compares them shortly after each falling edge.
module sim_lockdog_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sys_rst;
    logic        wdt_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 sys_rst, 2 wdt_irq
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_CTRL = 6'h08,
                           A_CLO = 6'h0C, A_CHI = 6'h10, A_LOCK = 6'h20;

    always #10 clk = ~clk;

    lockdog_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst(sys_rst), .wdt_irq(wdt_irq)
    );

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_rd(input logic [5:0] a, input logic [15:0] e, input string t);
        item_t it;
        bus_addr = a;
        it.kind = 0; it.exp = e; it.tag = t;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_pin(input int k, input logic e, input string t);
        item_t it;
        it.kind = k; it.exp = 16'(e); it.tag = t;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare every queued item against the live outputs.
    initial forever begin
        @(negedge clk);
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            act = (it.kind == 0) ? bus_rdata :
                  (it.kind == 1) ? 16'(sys_rst) : 16'(wdt_irq);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog on the bench itself.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        exp_rd(A_LOCK, 16'h0001, "R1 lock");
        exp_rd(A_CTRL, 16'h0000, "R1 ctrl");
        exp_rd(A_CLO,  16'h0000, "R1 cnt lo");
        exp_rd(A_CHI,  16'h0000, "R1 cnt hi");
        exp_pin(1, 1'b0, "R1 sys_rst");
        exp_pin(2, 1'b0, "R1 irq");
        // R3 locked writes discarded
        wr(A_LO, 16'h0010);
        exp_rd(A_CLO, 16'h0000, "R3 locked load");
        wr(A_CTRL, 16'h000E);
        exp_rd(A_CTRL, 16'h0000, "R3 locked ctrl");
        // R2 lock key
        wr(A_LOCK, 16'h1234);
        exp_rd(A_LOCK, 16'h0001, "R2 wrong key");
        wr(A_LOCK, 16'hE551);
        exp_rd(A_LOCK, 16'h0000, "R2 key unlocks");
        // R4 staged high half
        wr(A_HI, 16'h0001);
        exp_rd(A_CHI, 16'h0000, "R4 hi staged only");
        exp_rd(A_HI,  16'h0001, "R4 hi readback");
        wr(A_LO, 16'h0003);
        exp_rd(A_CLO, 16'h0003, "R4 commit lo");
        exp_rd(A_CHI, 16'h0001, "R4 commit hi");
        wr(A_HI, 16'h0000);
        wr(A_LO, 16'd1638);
        exp_rd(A_CLO, 16'd1638, "R4 50ms load");
        // R10 stopped counter holds
        tick(3);
        exp_rd(A_CLO, 16'd1638, "R10 hold");
        // R11 control read-back
        wr(A_CTRL, 16'hFFF1);
        exp_rd(A_CTRL, 16'h0000, "R11 masked bits");
        wr(A_LO, 16'h0005);
        wr(A_CTRL, 16'h000A);
        exp_rd(A_CTRL, 16'h000A, "R11 run+rst");
        // R5 counting only on ticks
        tick(2);
        exp_rd(A_CLO, 16'h0003, "R5 two ticks");
        idle(3);
        exp_rd(A_CLO, 16'h0003, "R5 no tick");
        tick(2);
        exp_pin(1, 1'b0, "R6 no pulse before zero");
        tick(1);
        // R6 pulse of four cycles
        for (int i = 0; i < 4; i++) exp_pin(1, 1'b1, "R6 pulse high");
        exp_pin(1, 1'b0, "R6 pulse ends");
        // R8 hold at zero, R9 no irq in plain mode
        exp_rd(A_CLO, 16'h0000, "R8 zero");
        tick(3);
        exp_rd(A_CLO, 16'h0000, "R8 held zero");
        exp_pin(2, 1'b0, "R9 irq off in plain mode");
        // R7 / R9 interrupt mode without reset
        wr(A_CTRL, 16'h0006);
        wr(A_LO, 16'h0002);
        tick(2);
        exp_pin(2, 1'b1, "R9 irq set");
        exp_pin(1, 1'b0, "R7 no reset");
        exp_pin(1, 1'b0, "R7 still no reset");
        tick(2);
        exp_pin(2, 1'b1, "R9 irq held");
        exp_rd(A_CLO, 16'h0000, "R8 zero in irq mode");
        wr(A_LO, 16'h0004);
        exp_pin(2, 1'b0, "R8 reload clears irq");
        exp_rd(A_CLO, 16'h0004, "R8 reload count");
        // R2 relock, R3 running counter unaffected by locked writes
        wr(A_LOCK, 16'h1AAE);
        exp_rd(A_LOCK, 16'h0001, "R2 relock");
        wr(A_CTRL, 16'h0000);
        exp_rd(A_CTRL, 16'h0006, "R3 ctrl kept");
        tick(1);
        exp_rd(A_CLO, 16'h0003, "R3 still running");
        wr(A_LO, 16'h0100);
        exp_rd(A_CLO, 16'h0003, "R3 load ignored");
        wr(A_HI, 16'h0055);
        exp_rd(A_HI, 16'h0000, "R3 hi ignored");
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule